// File: doc/BRIEF.md
# Grouped-Interrupt GPIO Port

This block is a general-purpose I/O port of up to 32 pins. Software programs it through a single-cycle register port. Each pin is either an input or an output, as its direction bit selects. An input pin is resynchronised to the core clock and may be inverted. It is then held in a shared value register, next to the levels that software drives onto output pins. Software can update outputs in three ways: a whole-word write, a set alias or a clear alias. None of these writes can disturb the sampled state of an input.

A low-to-high change in the stored value of an input pin records a pending cause bit for that pin. When the pin is also enabled in the mask, the change asserts the interrupt line of its byte lane. The lane is the pin index divided by the lane width, so with the defaults pins 0 to 7 drive line 0, pins 8 to 15 drive line 1, and so on.

A control bit selects how a lane interrupt is released:

- **Edge mode:** software releases it by clearing the cause bits.
- **Level mode:** it falls by itself once every stored value in its lane is zero.

Top module: `gpio_grp_port`

## Requirements
- R1: After reset every register reads 0, the direction, output and interrupt ports are all 0, and the mode register (word address 8) reads 0x11FF0000.
- R2: A write to the value register (address 2) updates only bits whose direction bit (address 0) is 1. Input bits keep their sampled level.
- R3: A write to the set alias (address 3) ORs the written bits into the value register, and a write to the clear alias (address 4) clears them. Both are limited to output pins, and both aliases read as 0.
- R4: An input pin whose polarity bit (address 1) is 1 is stored inverted. An input change reaches the value register, the cause register and the interrupt lines on the third rising clock edge after it appears on the pin.
- R5: A 0-to-1 change in the stored value of an input pin sets that pin's cause bit (address 5) whether it is masked or not. It asserts interrupt line pin/8 only when the pin's mask bit is 1.
- R6: Only bit 10 of the mode register is stored, where 1 selects level mode and 0 selects edge mode. Reads return 0x11FF0000 with that bit in position 10.
- R7: In level mode a lane interrupt stays asserted while any stored value bit of its lane is 1, whatever the cause register holds. It drops in the cycle its lane values all become 0. Writes to the cause register do not drop it.
- R8: In edge mode a lane interrupt is released only by a write to the cause register that changes that lane's cause bits and leaves them all 0. A falling input, or a write that leaves the lane's cause bits unchanged, keeps the interrupt asserted.
- R9: The mask register is reachable at addresses 6 and 7, and both addresses share one storage.
- R10: Value changes on output pins never set cause bits and never assert an interrupt.
- R11: `pinOe` reflects the direction register. `pinOut` carries the stored value register, so output pins show the level written by software.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Write strobe, one write per cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, same cycle |
| pinIn | input | NUM_PINS | Pin input levels, asynchronous |
| pinOut | output | NUM_PINS | Stored value register |
| pinOe | output | NUM_PINS | Output enable per pin (direction) |
| irqGroup | output | NUM_PINS/LANE_WIDTH | One interrupt per byte lane |

## Verification
The bench builds the port with its defaults: 32 pins, a lane width of 8 (four interrupt lines) and two synchronizer stages. The two-stage depth is what R4 fixes at three edges of input latency, and the bench samples exactly at that boundary. The 8-pin lanes let a masked and an unmasked input sit in different lanes. That isolates the per-lane release rules of the edge and level modes. It also lets a polarity change alone raise an interrupt with the pin held still.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int MODE_BIT = 10;
  localparam logic [REG_W-1:0] MODE_READ_BASE = 32'h11FF_0000;

  localparam logic [ADDR_W-1:0] ADDR_DIR    = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_POL    = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_VAL    = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_SET    = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLR    = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE  = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_MASK_A = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_MASK_B = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 4'd8;

  typedef enum logic [2:0] {
    RD_NONE, RD_DIR, RD_POL, RD_VAL, RD_CAUSE, RD_MASK, RD_MODE
  } rdSelE;

  typedef struct packed {
    logic  wrDir;
    logic  wrPol;
    logic  wrVal;
    logic  wrSet;
    logic  wrClr;
    logic  wrCause;
    logic  wrMask;
    logic  wrMode;
    rdSelE rdSel;
  } ctrlStrobesT;
endpackage

// File: rtl/gpio_grp_sync.sv
module gpio_grp_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_grp_ctrl.sv
module gpio_grp_ctrl
  import gpio_grp_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobesT       strobes
);
  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    unique case (regAddr)
      ADDR_DIR: begin
        strobes.wrDir = regWrEn;
        strobes.rdSel = RD_DIR;
      end
      ADDR_POL: begin
        strobes.wrPol = regWrEn;
        strobes.rdSel = RD_POL;
      end
      ADDR_VAL: begin
        strobes.wrVal = regWrEn;
        strobes.rdSel = RD_VAL;
      end
      ADDR_SET:   strobes.wrSet = regWrEn;
      ADDR_CLR:   strobes.wrClr = regWrEn;
      ADDR_CAUSE: begin
        strobes.wrCause = regWrEn;
        strobes.rdSel   = RD_CAUSE;
      end
      ADDR_MASK_A, ADDR_MASK_B: begin
        strobes.wrMask = regWrEn;
        strobes.rdSel  = RD_MASK;
      end
      ADDR_MODE: begin
        strobes.wrMode = regWrEn;
        strobes.rdSel  = RD_MODE;
      end
      default: strobes.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_grp_datapath.sv
module gpio_grp_datapath
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int LANE_WIDTH = 8,
  localparam int NUM_LANES = NUM_PINS / LANE_WIDTH
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobesT          strobes,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [NUM_PINS-1:0]  syncIn,
  output logic [REG_W-1:0]     regRdData,
  output logic [NUM_PINS-1:0]  valueOut,
  output logic [NUM_PINS-1:0]  dirOut,
  output logic [NUM_LANES-1:0] irqOut
);
  logic [NUM_PINS-1:0]  dirQ, polQ, valueQ, causeQ, maskQ;
  logic                 modeQ;
  logic [NUM_LANES-1:0] irqQ;

  logic [NUM_PINS-1:0]  wrBits, swVal, valueNext, rise, causeNext, causeDelta;
  logic [NUM_LANES-1:0] laneSet, laneEdgeClr, laneLevelClr, irqNext;

  assign wrBits = regWrData[NUM_PINS-1:0];

  // Software view of output bits, then merge with sampled inputs
  always_comb begin
    swVal = valueQ;
    if (strobes.wrVal)      swVal = wrBits;
    else if (strobes.wrSet) swVal = valueQ | wrBits;
    else if (strobes.wrClr) swVal = valueQ & ~wrBits;
    valueNext  = (dirQ & swVal) | (~dirQ & (syncIn ^ polQ));
    rise       = valueNext & ~valueQ & ~dirQ;
    causeNext  = (strobes.wrCause ? wrBits : causeQ) | rise;
    causeDelta = causeQ ^ wrBits;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LO = g * LANE_WIDTH;
    assign laneSet[g]      = |(rise[LO +: LANE_WIDTH] & maskQ[LO +: LANE_WIDTH]);
    assign laneEdgeClr[g]  = strobes.wrCause & ~modeQ
                           & (|causeDelta[LO +: LANE_WIDTH])
                           & ~(|wrBits[LO +: LANE_WIDTH]);
    assign laneLevelClr[g] = modeQ & ~(|valueNext[LO +: LANE_WIDTH]);
    assign irqNext[g]      = laneSet[g] | (irqQ[g] & ~(laneEdgeClr[g] | laneLevelClr[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      polQ   <= '0;
      valueQ <= '0;
      causeQ <= '0;
      maskQ  <= '0;
      modeQ  <= 1'b0;
      irqQ   <= '0;
    end else begin
      if (strobes.wrDir)  dirQ  <= wrBits;
      if (strobes.wrPol)  polQ  <= wrBits;
      if (strobes.wrMask) maskQ <= wrBits;
      if (strobes.wrMode) modeQ <= regWrData[MODE_BIT];
      valueQ <= valueNext;
      causeQ <= causeNext;
      irqQ   <= irqNext;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_DIR:   regRdData = REG_W'(dirQ);
      RD_POL:   regRdData = REG_W'(polQ);
      RD_VAL:   regRdData = REG_W'(valueQ);
      RD_CAUSE: regRdData = REG_W'(causeQ);
      RD_MASK:  regRdData = REG_W'(maskQ);
      RD_MODE:  regRdData = MODE_READ_BASE | (REG_W'(modeQ) << MODE_BIT);
      default:  regRdData = '0;
    endcase
  end

  assign valueOut = valueQ;
  assign dirOut   = dirQ;
  assign irqOut   = irqQ;
endmodule

// File: rtl/gpio_grp_port.sv
module gpio_grp_port
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int LANE_WIDTH  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_LANES  = NUM_PINS / LANE_WIDTH
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic [NUM_PINS-1:0]  pinIn,
  output logic [NUM_PINS-1:0]  pinOut,
  output logic [NUM_PINS-1:0]  pinOe,
  output logic [NUM_LANES-1:0] irqGroup
);
  ctrlStrobesT         strobes;
  logic [NUM_PINS-1:0] syncIn;

  gpio_grp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (syncIn)
  );

  gpio_grp_ctrl i_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  gpio_grp_datapath #(.NUM_PINS(NUM_PINS), .LANE_WIDTH(LANE_WIDTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWrData (regWrData),
    .syncIn    (syncIn),
    .regRdData (regRdData),
    .valueOut  (pinOut),
    .dirOut    (pinOe),
    .irqOut    (irqGroup)
  );
endmodule

// File: rtl/gpio_grp_checker.sv
module gpio_grp_checker
  import gpio_grp_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter int NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWrEn,
  input logic                 modeWrBit,
  input logic [REG_W-1:0]     regRdData,
  input logic [NUM_PINS-1:0]  pinOe,
  input logic [NUM_LANES-1:0] irqGroup
);
  logic modeShadow;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeShadow <= 1'b0;
    else if (regWrEn && regAddr == ADDR_MODE) modeShadow <= modeWrBit;
  end

  a_r1_irq_clear_in_reset: assert property (@(posedge clk)
    !rstN |=> irqGroup == '0);

  a_r3_alias_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_SET || regAddr == ADDR_CLR) |-> regRdData == '0);

  a_r6_mode_readback: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_MODE) |-> (regRdData & ~(32'h1 << MODE_BIT)) == MODE_READ_BASE);

  a_r11_oe_needs_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn && regAddr == ADDR_DIR) |-> $stable(pinOe));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_chk
    a_r8_edge_fall_needs_cause_write: assert property (@(posedge clk) disable iff (!rstN)
      ($past(!modeShadow) && $fell(irqGroup[g])) |-> $past(regWrEn && regAddr == ADDR_CAUSE));
  end
endmodule

bind gpio_grp_port gpio_grp_checker #(.NUM_PINS(NUM_PINS), .NUM_LANES(NUM_LANES)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .modeWrBit (regWrData[gpio_grp_pkg::MODE_BIT]),
  .regRdData (regRdData),
  .pinOe     (pinOe),
  .irqGroup  (irqGroup)
);

// File: tb/test_gpio_grp_port.sv
`timescale 1ns/100ps
module test_gpio_grp_port;
  localparam int NP = 32;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic [NL-1:0] irqGroup;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_grp_port i_gpio_grp_port (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqGroup(irqGroup)
  );

  typedef struct packed {
    logic        isWr;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vecT;

  localparam int NV = 19;
  localparam vecT VECS [NV] = '{
    '{1'b1, 4'd6, 32'h1234_5678, 8'd9},   // R9 mask via first address
    '{1'b0, 4'd7, 32'h1234_5678, 8'd9},   // R9 read via alias
    '{1'b1, 4'd7, 32'h00FF_FFFF, 8'd9},   // R9 write via alias
    '{1'b0, 4'd6, 32'h00FF_FFFF, 8'd9},   // R9
    '{1'b1, 4'd0, 32'h0000_FFFF, 8'd2},   // R2 low half outputs
    '{1'b0, 4'd0, 32'h0000_FFFF, 8'd2},   // R2
    '{1'b1, 4'd2, 32'hA5A5_A5A5, 8'd2},   // R2
    '{1'b0, 4'd2, 32'h0000_A5A5, 8'd2},   // R2 inputs untouched
    '{1'b1, 4'd3, 32'h00FF_0F00, 8'd3},   // R3 set alias
    '{1'b0, 4'd2, 32'h0000_AFA5, 8'd3},   // R3
    '{1'b0, 4'd3, 32'h0000_0000, 8'd3},   // R3 set reads 0
    '{1'b0, 4'd4, 32'h0000_0000, 8'd3},   // R3 clear reads 0
    '{1'b1, 4'd4, 32'hFFFF_00A5, 8'd3},   // R3 clear alias
    '{1'b0, 4'd2, 32'h0000_AF00, 8'd3},   // R3
    '{1'b1, 4'd8, 32'hFFFF_FFFF, 8'd6},   // R6
    '{1'b0, 4'd8, 32'h11FF_0400, 8'd6},   // R6
    '{1'b1, 4'd8, 32'h0000_0000, 8'd6},   // R6
    '{1'b0, 4'd8, 32'h11FF_0000, 8'd6},   // R6
    '{1'b0, 4'd5, 32'h0000_0000, 8'd10}   // R10 output rises leave cause clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input string tag, input logic [3:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 irq", 32'(irqGroup), 32'h0);
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 pinOut", pinOut, 32'h0);
    rstN = 1'b1;
    step(1);
    regRead("R1 dir", 4'd0, 32'h0);
    regRead("R1 cause", 4'd5, 32'h0);
    regRead("R1 mode", 4'd8, 32'h11FF_0000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isWr) regWrite(VECS[i].addr, VECS[i].data);
      else regRead($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
    end

    // R10: output rises with mask set raised nothing
    check("R10 irq", 32'(irqGroup), 32'h0);
    // R11 pin outputs
    check("R11 pinOe", pinOe, 32'h0000_FFFF);
    check("R11 pinOut", pinOut, 32'h0000_AF00);

    // R4/R5: masked input pin 16 rises -> lane 2 after three edges
    pinIn = 32'h0001_0000;
    step(2);
    check("R4 not yet", 32'(irqGroup), 32'h0);
    step(1);
    check("R5 irq lane2", 32'(irqGroup), 32'h4);
    regRead("R4 value", 4'd2, 32'h0001_AF00);
    regRead("R5 cause", 4'd5, 32'h0001_0000);

    // R5: unmasked pin 24 sets cause only
    pinIn = 32'h0101_0000;
    step(3);
    regRead("R5 cause unmasked", 4'd5, 32'h0101_0000);
    check("R5 unmasked irq", 32'(irqGroup), 32'h4);

    // R8: edge mode, falling input keeps interrupt
    pinIn = 32'h0100_0000;
    step(3);
    check("R8 fall keeps", 32'(irqGroup), 32'h4);
    regRead("R8 value", 4'd2, 32'h0100_AF00);
    regWrite(4'd5, 32'h0001_0000);
    check("R8 lane unchanged keeps", 32'(irqGroup), 32'h4);
    regWrite(4'd5, 32'h0);
    check("R8 cleared", 32'(irqGroup), 32'h0);
    regRead("R8 cause", 4'd5, 32'h0);

    // R4: polarity flip on still pin 17 raises lane 2
    regWrite(4'd1, 32'h0002_0000);
    step(1);
    check("R4 pol irq", 32'(irqGroup), 32'h4);
    regRead("R4 pol value", 4'd2, 32'h0102_AF00);
    regRead("R4 pol cause", 4'd5, 32'h0002_0000);

    // R7: level mode, lane drops when its values go to zero
    regWrite(4'd8, 32'h0000_0400);
    regWrite(4'd1, 32'h0);
    step(1);
    check("R7 level drop", 32'(irqGroup), 32'h0);
    regRead("R7 cause kept", 4'd5, 32'h0002_0000);
    pinIn = 32'h0101_0000;
    step(3);
    check("R7 level raise", 32'(irqGroup), 32'h4);
    regWrite(4'd5, 32'h0);
    check("R7 cause write ignored", 32'(irqGroup), 32'h4);
    pinIn = 32'h0100_0000;
    step(3);
    check("R7 level fall", 32'(irqGroup), 32'h0);

    done = 1'b1;
    finishRun();
  end
endmodule